// File: doc/BRIEF.md
# Serial Control-Bus Peripheral

This block is the peripheral end of a four-wire serial control bus: an active-low select, a serial clock, a host-to-peripheral command line and a peripheral-to-host reply line. Every frame opens with an address byte. That byte alone fixes the frame's length and direction. A frame can be a bare command with no data, a write of one or two bytes on the command line, or a read of one or two bytes returned on the reply line. The block keeps a small file of 8-bit and 16-bit registers. The reply line floats at all other times.

All four bus inputs pass through synchronizers into the system clock domain, where clock edges are detected. Input bits count on rising serial-clock edges. Reply bits change after falling edges. Byte framing comes only from edge counts while select is low, so idle clock level and inter-byte gaps do not matter. A completed write updates its register and raises a one-cycle strobe in the system domain carrying the address and data.

Top module: `cb_periph`

## Requirements
- R1: Address and data bits are taken MSB first on rising serial-clock edges. Address 0x1n writes one byte into 8-bit register n.
- R2: Address 0x2n writes 16-bit register n from two bytes, high byte first.
- R3: Address 0x3n returns 8-bit register n and 0x4n returns 16-bit register n on the reply line, MSB first. Each bit changes after a falling edge and is valid at the following rising edge.
- R4: `reply_oe` is high only while read data bits are being returned. It is low during address bits, during write and command frames, and once select is released. `reply` is high-impedance whenever `reply_oe` is low.
- R5: The 8-bit command 0x01 returns every register to its default value (8-bit registers 0xA5, 16-bit registers 0x1234) and produces no write strobe.
- R6: A write produces exactly one single-cycle `wr_stb` after the last data bit. `wr_addr` holds the address byte and `wr_data` holds the value, zero-extended for 8-bit writes.
- R7: If select rises before the final data bit, the frame is dropped: no strobe is produced and no register changes.
- R8: Any address outside the map (command 0x01 and groups 0x1n to 0x4n) makes the rest of the frame inert: no strobe, no register change, no reply drive.
- R9: Frames decode the same whether the serial clock idles high or low.
- R10: Any pause between bytes leaves framing unchanged.
- R11: Synchronous reset clears `wr_stb` and `reply_oe` and loads the defaults of R5.
- R12: Clock edges beyond a frame's length are ignored. A write with extra bits stores only its own bytes and strobes once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csn | input | 1 | Bus select, active low |
| sclk | input | 1 | Serial clock |
| cmd_in | input | 1 | Host-to-peripheral serial data |
| reply | output | 1 | Peripheral-to-host serial data, high-impedance when idle |
| reply_oe | output | 1 | High while `reply` is driven |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | 8 | Address byte of the completed write |
| wr_data | output | 16 | Data of the completed write |

## Verification
The checks assume the system clock is much faster than the serial clock. Each serial-clock level and each select change must last several system cycles longer than the synchronizer depth, so every bus edge is seen exactly once. The bench holds every serial-clock level for eight system cycles. It keeps select stable for eight cycles on each side of a frame, and it changes the command line only while the serial clock is low. Inter-byte gaps are added only with the clock held high.

// File: rtl/cb_pkg.sv
package cb_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int CNT_W  = 5;

  typedef enum logic [1:0] {PH_ADDR, PH_WR, PH_RD, PH_SKIP} phase_e;
  typedef enum logic [2:0] {AC_NONE, AC_RESET, AC_W8, AC_W16, AC_R8, AC_R16} acls_e;

  localparam logic [7:0] CMD_RESET = 8'h01;
  localparam logic [3:0] GRP_W8    = 4'h1;
  localparam logic [3:0] GRP_W16   = 4'h2;
  localparam logic [3:0] GRP_R8    = 4'h3;
  localparam logic [3:0] GRP_R16   = 4'h4;

  function automatic acls_e classify(input logic [7:0] a, input int unsigned nreg);
    acls_e c;
    c = AC_NONE;
    if (a == CMD_RESET) begin
      c = AC_RESET;
    end else if (32'(a[3:0]) < nreg) begin
      case (a[7:4])
        GRP_W8:  c = AC_W8;
        GRP_W16: c = AC_W16;
        GRP_R8:  c = AC_R8;
        GRP_R16: c = AC_R16;
        default: c = AC_NONE;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/cb_sync.sv
module cb_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[0] <= RST_VAL;
        else     st[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[g] <= RST_VAL;
        else     st[g] <= st[g-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/cb_frame.sv
module cb_frame
  import cb_pkg::*;
#(
  parameter int NREG = 16,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              din_s,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [BYTE_W-1:0] rd8,
  input  logic [WORD_W-1:0] rd16,
  output logic              wr_en,
  output logic              wr_wide,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [7:0]        wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              cmd_clr,
  output logic              rbit,
  output logic              oe
);
  phase_e            phase;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sh;
  logic              sclk_q;
  logic              rise, fall;
  logic [7:0]        addr_next;
  logic [CNT_W-1:0]  last_bit;
  acls_e             cls;

  assign rise      = sclk_s & ~sclk_q & ~cs_n_s;
  assign fall      = ~sclk_s & sclk_q & ~cs_n_s;
  assign addr_next = {sh[6:0], din_s};
  assign rd_idx    = addr_next[IDX_W-1:0];
  assign cls       = classify(addr_next, NREG);
  assign last_bit  = wr_wide ? CNT_W'(WORD_W - 1) : CNT_W'(BYTE_W - 1);

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk_s;
  end

  always_ff @(posedge clk) begin
    wr_en   <= 1'b0;
    cmd_clr <= 1'b0;
    if (rst) begin
      phase   <= PH_ADDR;
      cnt     <= '0;
      sh      <= '0;
      oe      <= 1'b0;
      rbit    <= 1'b0;
      wr_wide <= 1'b0;
      wr_idx  <= '0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (cs_n_s) begin
      phase <= PH_ADDR;
      cnt   <= '0;
      oe    <= 1'b0;
    end else begin
      if (rise) begin
        case (phase)
          PH_ADDR: begin
            sh  <= {sh[WORD_W-2:0], din_s};
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(BYTE_W - 1)) begin
              cnt     <= '0;
              wr_addr <= addr_next;
              wr_idx  <= addr_next[IDX_W-1:0];
              case (cls)
                AC_RESET: begin cmd_clr <= 1'b1; phase <= PH_SKIP; end
                AC_W8:    begin wr_wide <= 1'b0; phase <= PH_WR; end
                AC_W16:   begin wr_wide <= 1'b1; phase <= PH_WR; end
                AC_R8:    begin wr_wide <= 1'b0; phase <= PH_RD; sh <= {rd8, 8'h00}; end
                AC_R16:   begin wr_wide <= 1'b1; phase <= PH_RD; sh <= rd16; end
                default:  phase <= PH_SKIP;
              endcase
            end
          end
          PH_WR: begin
            sh  <= {sh[WORD_W-2:0], din_s};
            cnt <= cnt + 1'b1;
            if (cnt == last_bit) begin
              wr_en   <= 1'b1;
              wr_data <= wr_wide ? {sh[WORD_W-2:0], din_s}
                                 : {8'h00, sh[BYTE_W-2:0], din_s};
              phase   <= PH_SKIP;
            end
          end
          PH_RD: begin
            cnt <= cnt + 1'b1;
            if (cnt == last_bit) phase <= PH_SKIP;
          end
          default: ;
        endcase
      end
      if (fall) begin
        if (phase == PH_RD) begin
          oe   <= 1'b1;
          rbit <= sh[WORD_W-1];
          sh   <= {sh[WORD_W-2:0], 1'b0};
        end else begin
          oe <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cb_regfile.sv
module cb_regfile
  import cb_pkg::*;
#(
  parameter int NREG = 16,
  parameter logic [BYTE_W-1:0] RST8 = 8'hA5,
  parameter logic [WORD_W-1:0] RST16 = 16'h1234,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic              wide,
  input  logic [IDX_W-1:0]  widx,
  input  logic [7:0]        waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [BYTE_W-1:0] rd8,
  output logic [WORD_W-1:0] rd16,
  output logic              stb,
  output logic [7:0]        stb_addr,
  output logic [WORD_W-1:0] stb_data
);
  logic [BYTE_W-1:0] r8  [NREG];
  logic [WORD_W-1:0] r16 [NREG];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < NREG; i++) begin
        r8[i]  <= RST8;
        r16[i] <= RST16;
      end
    end else if (we) begin
      if (wide) r16[widx] <= wdata;
      else      r8[widx]  <= wdata[BYTE_W-1:0];
    end
  end

  assign rd8  = r8[ridx];
  assign rd16 = r16[ridx];

  always_ff @(posedge clk) begin
    if (rst) begin
      stb      <= 1'b0;
      stb_addr <= '0;
      stb_data <= '0;
    end else begin
      stb <= we;
      if (we) begin
        stb_addr <= waddr;
        stb_data <= wdata;
      end
    end
  end
endmodule

// File: rtl/cb_periph.sv
module cb_periph
  import cb_pkg::*;
#(
  parameter int NREG = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] RST8 = 8'hA5,
  parameter logic [15:0] RST16 = 16'h1234
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        csn,
  input  logic        sclk,
  input  logic        cmd_in,
  output logic        reply,
  output logic        reply_oe,
  output logic        wr_stb,
  output logic [7:0]  wr_addr,
  output logic [15:0] wr_data
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [2:0]        sync_q;
  logic              cs_n_s, sclk_s, din_s;
  logic [IDX_W-1:0]  rd_idx, f_idx;
  logic [BYTE_W-1:0] rd8;
  logic [WORD_W-1:0] rd16, f_data;
  logic              f_we, f_wide, f_clr, rbit;
  logic [7:0]        f_addr;

  cb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({csn, sclk, cmd_in}), .q(sync_q)
  );
  assign {cs_n_s, sclk_s, din_s} = sync_q;

  cb_frame #(.NREG(NREG)) u_frame (
    .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .sclk_s(sclk_s), .din_s(din_s),
    .rd_idx(rd_idx), .rd8(rd8), .rd16(rd16),
    .wr_en(f_we), .wr_wide(f_wide), .wr_idx(f_idx), .wr_addr(f_addr),
    .wr_data(f_data), .cmd_clr(f_clr), .rbit(rbit), .oe(reply_oe)
  );

  cb_regfile #(.NREG(NREG), .RST8(RST8), .RST16(RST16)) u_regs (
    .clk(clk), .rst(rst), .clr(f_clr), .we(f_we), .wide(f_wide),
    .widx(f_idx), .waddr(f_addr), .wdata(f_data), .ridx(rd_idx),
    .rd8(rd8), .rd16(rd16), .stb(wr_stb), .stb_addr(wr_addr), .stb_data(wr_data)
  );

  assign reply = reply_oe ? rbit : 1'bz;
endmodule

// File: rtl/cb_periph_chk.sv
module cb_periph_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n_s,
  input logic       reply_oe,
  input logic       wr_stb,
  input logic [7:0] wr_addr
);
  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  assert_strobe_addr_R6: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (wr_addr[7:4] == 4'h1 || wr_addr[7:4] == 4'h2));

  assert_strobe_in_frame_R7: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $past(!cs_n_s));

  assert_release_on_deselect_R4: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !reply_oe);

  assert_no_drive_on_write_R4: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> !reply_oe);

  assert_reset_idle_R11: assert property (@(posedge clk)
    rst |=> (!wr_stb && !reply_oe));
endmodule

bind cb_periph cb_periph_chk u_chk (
  .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .reply_oe(reply_oe),
  .wr_stb(wr_stb), .wr_addr(wr_addr)
);

// File: tb/tb_cb_periph.sv
module tb_cb_periph;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csn = 1'b1;
  logic sclk = 1'b0;
  logic cmd_in = 1'b0;
  wire  reply;
  logic reply_oe, wr_stb;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;

  int checks = 0;
  int fails = 0;
  int stb_cnt = 0;
  logic [7:0]  stb_addr = '0;
  logic [15:0] stb_data = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cb_periph dut (
    .clk(clk), .rst(rst), .csn(csn), .sclk(sclk), .cmd_in(cmd_in),
    .reply(reply), .reply_oe(reply_oe), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(negedge clk) begin
    if (wr_stb) begin
      stb_cnt  = stb_cnt + 1;
      stb_addr = wr_addr;
      stb_data = wr_data;
    end
  end

  // {address, data sent MSB first}
  localparam logic [23:0] VEC [6] = '{
    {8'h10, 16'h3C00}, {8'h1F, 16'hC100}, {8'h15, 16'h8000},
    {8'h20, 16'hBEEF}, {8'h2F, 16'h0001}, {8'h27, 16'h8421}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] a, input int nd, input logic [15:0] wd,
                      input bit idle_hi, input int gap, input bit is_rd,
                      output logic [15:0] rd, output int oe_err);
    rd = '0;
    oe_err = 0;
    sclk = idle_hi;
    tick(8);
    csn = 1'b0;
    tick(8);
    for (int i = 0; i < 8 + nd; i++) begin
      sclk = 1'b0;
      cmd_in = (i < 8) ? a[7-i] : (is_rd ? 1'b0 : wd[15-(i-8)]);
      tick(8);
      if (reply_oe !== (is_rd && i >= 8)) oe_err++;
      if (is_rd && i >= 8) rd = {rd[14:0], reply};
      sclk = 1'b1;
      tick(8);
      if ((i == 7 || i == 15) && gap > 0) tick(gap);
    end
    if (!idle_hi) begin
      sclk = 1'b0;
      tick(8);
    end
    csn = 1'b1;
    cmd_in = 1'b0;
    tick(8);
    if (reply_oe !== 1'b0) oe_err++;
  endtask

  task automatic rd_reg(input logic [7:0] a, input logic [15:0] exp, input string req);
    logic [15:0] r;
    int e;
    int n;
    n = (a[7:4] == 4'h4) ? 16 : 8;
    xfer(a, n, 16'h0, 1'b0, 0, 1'b1, r, e);
    chk(req, 32'(r), 32'(exp));
    chk("R4 reply enable during read", 32'(e), 32'd0);
  endtask

  initial begin
    logic [15:0] r;
    int e;
    int s0;
    tick(5);
    rst = 1'b0;
    tick(4);
    // R11 reset state
    chk("R11 strobe low after reset", 32'(wr_stb), 32'd0);
    chk("R11 reply released after reset", 32'(reply_oe), 32'd0);
    rd_reg(8'h31, 16'h00A5, "R11 8-bit default");
    rd_reg(8'h43, 16'h1234, "R11 16-bit default");

    // Table walk: writes (R1 R2 R6 R9 R10) then read-back (R3)
    for (int i = 0; i < 6; i++) begin
      logic [7:0]  a;
      logic [15:0] d;
      int n;
      a = VEC[i][23:16];
      d = VEC[i][15:0];
      n = a[5] ? 16 : 8;
      s0 = stb_cnt;
      xfer(a, n, d, (i % 2) == 1, i * 5, 1'b0, r, e);
      chk("R6 one strobe per write", 32'(stb_cnt - s0), 32'd1);
      chk("R6 strobe address", 32'(stb_addr), 32'(a));
      chk(a[5] ? "R2 16-bit write data" : "R1 8-bit write data",
          32'(stb_data), a[5] ? 32'(d) : 32'(d[15:8]));
      chk("R4 no reply drive on write (R9 R10 framing)", 32'(e), 32'd0);
    end
    for (int i = 0; i < 6; i++) begin
      logic [7:0]  a;
      logic [15:0] d;
      a = VEC[i][23:16];
      d = VEC[i][15:0];
      rd_reg(a + 8'h20, a[5] ? d : {8'h00, d[15:8]}, "R3 read-back");
    end

    // R7 aborted write
    s0 = stb_cnt;
    xfer(8'h10, 4, 16'hF000, 1'b0, 0, 1'b0, r, e);
    chk("R7 no strobe on aborted frame", 32'(stb_cnt - s0), 32'd0);
    rd_reg(8'h30, 16'h003C, "R7 register unchanged");

    // R8 unmapped addresses
    s0 = stb_cnt;
    xfer(8'h77, 16, 16'hFFFF, 1'b1, 3, 1'b0, r, e);
    chk("R8 no reply drive for unmapped", 32'(e), 32'd0);
    xfer(8'h50, 16, 16'h10FF, 1'b0, 0, 1'b0, r, e);
    chk("R8 no strobe for unmapped", 32'(stb_cnt - s0), 32'd0);
    rd_reg(8'h30, 16'h003C, "R8 registers unchanged");

    // R12 extra bits after an 8-bit write
    s0 = stb_cnt;
    xfer(8'h11, 16, 16'h5AC3, 1'b0, 0, 1'b0, r, e);
    chk("R12 single strobe with extra bits", 32'(stb_cnt - s0), 32'd1);
    chk("R12 only first byte stored", 32'(stb_data), 32'h5A);
    rd_reg(8'h31, 16'h005A, "R12 read-back");

    // R5 reset command
    s0 = stb_cnt;
    xfer(8'h01, 0, 16'h0, 1'b1, 0, 1'b0, r, e);
    chk("R5 no strobe on reset command", 32'(stb_cnt - s0), 32'd0);
    rd_reg(8'h30, 16'h00A5, "R5 8-bit default restored");
    rd_reg(8'h40, 16'h1234, "R5 16-bit default restored");
    rd_reg(8'h4F, 16'h1234, "R5 16-bit top register restored");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule